// File: doc/BRIEF.md
# Single-Accumulator Multicycle Processor Core

This block is a small processor that keeps one working register, the accumulator, and runs a program held in the same word-addressed memory as its data. Every instruction is one 16-bit word: the top four bits choose the operation and the low twelve bits name a memory word directly. Three operations do work: copy a memory word into the accumulator (code 1), copy the accumulator out to a memory word (code 2), and add a memory word into the accumulator (code 5). Code 0 and every other code stop the machine.

Execution alternates between an instruction fetch and its execution, one instruction at a time, with no overlap. Every address the core places on the memory comes from its address holding register, and every word read or written passes through its data holding register. The memory is a synchronous single-port array with one cycle of read latency, so each read costs a wait cycle before the data is captured. The accumulator and a stop flag are brought out so that the surrounding logic can watch the result.

Top module: `acc_core`

## Requirements
- R1: After reset the accumulator reads 0, the stop flag reads 0, and the first memory read is issued to address 0.
- R2: Instruction words are fetched from consecutive addresses starting at 0; each fetch is followed, for codes 1 and 5 only, by one operand read at the address held in bits 11:0, and by nothing else for other codes.
- R3: Code 1 in bits 15:12 replaces the accumulator with the memory word at the address in bits 11:0.
- R4: Code 2 writes the accumulator to the address in bits 11:0 in one write cycle, leaving the accumulator unchanged; the write data equals the accumulator.
- R5: Code 5 adds the memory word at the address in bits 11:0 to the accumulator, modulo 2^16, with no flag kept.
- R6: Code 0 and any code other than 1, 2 or 5 raise the stop flag, which then stays high, and no further memory read or write is issued.
- R7: Read enable and write enable are never high together, and a read is never issued in two consecutive cycles.
- R8: Counted in clock edges from reset release, a code 1 or 5 instruction takes 8 cycles, a code 2 instruction 6 cycles, and the stop flag rises 5 edges after the fetch of a stopping instruction begins.
- R9: The accumulator changes only three cycles after an operand read was issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| mem_addr | output | 12 | Word address to the memory |
| mem_re | output | 1 | Read request; data returns one cycle later |
| mem_we | output | 1 | Write request for the addressed word |
| mem_wdata | output | 16 | Word to be written |
| mem_rdata | input | 16 | Word returned by the memory |
| acc_out | output | 16 | Current accumulator value |
| halted | output | 1 | High once a stopping instruction has been decoded |

## Verification
The bench builds the core with its default widths: a 16-bit word, a 4-bit operation field and a 12-bit address, so the whole 4096-word address space is reachable and wraparound of the 16-bit sum can be forced with directed values such as 0xFFFF plus 2. Random programs mix the three working codes over a small data window so loads, stores and adds reuse the same words, and each ends with a randomly chosen stopping code, covering both code 0 and undefined codes. Cycle count, the trace of read addresses, the final accumulator and the final data window are compared against a reference interpreter in the bench.

// File: rtl/acc_pkg.sv
package acc_pkg;

    parameter int WORD_W = 16;
    parameter int OPC_W  = 4;
    parameter int ADR_W  = WORD_W - OPC_W;

    // operation codes carried in the top field of an instruction word
    parameter logic [OPC_W-1:0] OPC_LOAD  = 4'd1;
    parameter logic [OPC_W-1:0] OPC_STORE = 4'd2;
    parameter logic [OPC_W-1:0] OPC_ADD   = 4'd5;

    typedef enum logic [1:0] {
        K_STOP  = 2'd0,
        K_LOAD  = 2'd1,
        K_STORE = 2'd2,
        K_ADD   = 2'd3
    } op_kind_e;

    typedef enum logic [3:0] {
        ST_FETCH_SET  = 4'd0,
        ST_FETCH_RD   = 4'd1,
        ST_FETCH_WAIT = 4'd2,
        ST_FETCH_IR   = 4'd3,
        ST_DECODE     = 4'd4,
        ST_OPND_RD    = 4'd5,
        ST_OPND_WAIT  = 4'd6,
        ST_EXEC       = 4'd7,
        ST_STORE_WR   = 4'd8,
        ST_STOP       = 4'd9
    } core_state_e;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
    import acc_pkg::*;
#(
    parameter int OP_W = acc_pkg::OPC_W
) (
    input  logic [OP_W-1:0] opcode,
    output op_kind_e        kind
);
    always_comb begin
        if (opcode == OPC_LOAD)       kind = K_LOAD;
        else if (opcode == OPC_STORE) kind = K_STORE;
        else if (opcode == OPC_ADD)   kind = K_ADD;
        else                          kind = K_STOP;
    end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_pkg::*;
#(
    parameter int DATA_W = acc_pkg::WORD_W
) (
    input  op_kind_e          kind,
    input  logic [DATA_W-1:0] acc,
    input  logic [DATA_W-1:0] operand,
    output logic [DATA_W-1:0] result
);
    always_comb begin
        case (kind)
            K_LOAD:  result = operand;
            K_ADD:   result = acc + operand;   // wraps, carry discarded
            default: result = acc;
        endcase
    end
endmodule

// File: rtl/acc_core.sv
module acc_core
    import acc_pkg::*;
#(
    parameter int DATA_W = acc_pkg::WORD_W,
    parameter int OP_W   = acc_pkg::OPC_W,
    localparam int ADDR_W = DATA_W - OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_re,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic [DATA_W-1:0] acc_out,
    output logic              halted
);

    typedef struct packed {
        core_state_e       state;
        logic [ADDR_W-1:0] pc;
        logic [DATA_W-1:0] ir;
        logic [DATA_W-1:0] acc;
        logic [ADDR_W-1:0] mar;
        logic [DATA_W-1:0] mbr;
    } core_regs_t;

    core_regs_t r_q, r_d;

    op_kind_e          kind;
    logic [DATA_W-1:0] alu_res;
    logic [ADDR_W-1:0] ir_addr;

    assign ir_addr = r_q.ir[ADDR_W-1:0];

    acc_decode #(.OP_W(OP_W)) u_dec (
        .opcode (r_q.ir[DATA_W-1:ADDR_W]),
        .kind   (kind)
    );

    acc_alu #(.DATA_W(DATA_W)) u_alu (
        .kind    (kind),
        .acc     (r_q.acc),
        .operand (r_q.mbr),
        .result  (alu_res)
    );

    always_comb begin
        r_d = r_q;
        case (r_q.state)
            ST_FETCH_SET: begin
                r_d.mar   = r_q.pc;
                r_d.state = ST_FETCH_RD;
            end
            ST_FETCH_RD: begin
                r_d.state = ST_FETCH_WAIT;
            end
            ST_FETCH_WAIT: begin
                r_d.mbr   = mem_rdata;
                r_d.state = ST_FETCH_IR;
            end
            ST_FETCH_IR: begin
                r_d.ir    = r_q.mbr;
                r_d.pc    = r_q.pc + 1'b1;
                r_d.state = ST_DECODE;
            end
            ST_DECODE: begin
                r_d.mar = ir_addr;
                case (kind)
                    K_LOAD, K_ADD: r_d.state = ST_OPND_RD;
                    K_STORE: begin
                        r_d.mbr   = r_q.acc;
                        r_d.state = ST_STORE_WR;
                    end
                    default: r_d.state = ST_STOP;
                endcase
            end
            ST_OPND_RD: begin
                r_d.state = ST_OPND_WAIT;
            end
            ST_OPND_WAIT: begin
                r_d.mbr   = mem_rdata;
                r_d.state = ST_EXEC;
            end
            ST_EXEC: begin
                r_d.acc   = alu_res;
                r_d.state = ST_FETCH_SET;
            end
            ST_STORE_WR: begin
                r_d.state = ST_FETCH_SET;
            end
            default: begin
                r_d.state = ST_STOP;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q.state <= ST_FETCH_SET;
            r_q.pc    <= '0;
            r_q.ir    <= '0;
            r_q.acc   <= '0;
            r_q.mar   <= '0;
            r_q.mbr   <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mem_addr  = r_q.mar;
    assign mem_re    = (r_q.state == ST_FETCH_RD) || (r_q.state == ST_OPND_RD);
    assign mem_we    = (r_q.state == ST_STORE_WR);
    assign mem_wdata = r_q.mbr;
    assign acc_out   = r_q.acc;
    assign halted    = (r_q.state == ST_STOP);

endmodule

// File: rtl/acc_core_chk.sv
module acc_core_chk #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_re,
    input logic              mem_we,
    input logic [DATA_W-1:0] mem_wdata,
    input logic [DATA_W-1:0] acc_out,
    input logic              halted
);

    p_rw_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_re && mem_we));

    p_read_gap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        mem_re |=> !mem_re);

    p_stop_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |=> halted);

    p_stop_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
        halted |-> (!mem_re && !mem_we));

    p_store_data_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_wdata == acc_out));

    p_store_keeps_acc_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> $stable(acc_out));

    p_acc_after_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(acc_out) |-> $past(mem_re, 3));

endmodule

bind acc_core acc_core_chk #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_re    (mem_re),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .acc_out   (acc_out),
    .halted    (halted)
);

// File: tb/tb_acc_core.sv
module tb_acc_core;

    localparam int DW = 16;
    localparam int AW = 12;
    localparam int MEMN = 1 << AW;
    localparam int LOGN = 1024;
    localparam int DBASE = 12'h800;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] mem_addr;
    logic          mem_re, mem_we;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic [DW-1:0] acc_out;
    logic          halted;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    acc_core dut (
        .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_re(mem_re),
        .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .acc_out(acc_out), .halted(halted)
    );

    // memory model and access log
    logic [DW-1:0] mem [MEMN];
    logic [AW-1:0] rlog [LOGN];
    int rlog_n;
    int wr_n;

    always @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wdata;
        if (mem_re) mem_rdata <= mem[mem_addr];
        if (!rst_n) begin
            rlog_n <= 0;
            wr_n   <= 0;
        end else begin
            if (mem_re) begin
                if (rlog_n < LOGN) rlog[rlog_n] <= mem_addr;
                rlog_n <= rlog_n + 1;
            end
            if (mem_we) wr_n <= wr_n + 1;
        end
    end

    // reference state
    logic [DW-1:0] ref_mem [MEMN];
    logic [AW-1:0] exp_log [LOGN];
    int            exp_log_n;
    int            exp_wr_n;
    int            exp_cyc;
    logic [DW-1:0] exp_acc;

    task automatic report;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        #(4 * 150000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: run did not complete (act=hung exp=done)");
        report();
    end

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint expv);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: act=%0h exp=%0h", req, what, act, expv);
        end
    endtask

    function automatic bit is_work(input logic [3:0] op);
        return (op == 4'd1) || (op == 4'd2) || (op == 4'd5);
    endfunction

    function automatic logic [3:0] stop_code();
        logic [3:0] v;
        v = 4'($urandom % 16);
        while (is_work(v)) v = 4'($urandom % 16);
        return v;
    endfunction

    // reference interpreter from the requirements
    task automatic run_ref;
        int pc = 0;
        logic [DW-1:0] w;
        logic [3:0] op;
        logic [AW-1:0] a;
        for (int i = 0; i < MEMN; i++) ref_mem[i] = mem[i];
        exp_acc = '0; exp_log_n = 0; exp_wr_n = 0; exp_cyc = 0;
        for (int step = 0; step < 500; step++) begin
            w  = ref_mem[pc];
            op = w[15:12];
            a  = w[11:0];
            exp_log[exp_log_n++] = AW'(pc);
            pc = (pc + 1) % MEMN;
            if (op == 4'd1) begin
                exp_log[exp_log_n++] = a; exp_acc = ref_mem[a]; exp_cyc += 8;
            end else if (op == 4'd5) begin
                exp_log[exp_log_n++] = a; exp_acc = exp_acc + ref_mem[a]; exp_cyc += 8;
            end else if (op == 4'd2) begin
                ref_mem[a] = exp_acc; exp_wr_n++; exp_cyc += 6;
            end else begin
                exp_cyc += 5;
                break;
            end
        end
    endtask

    task automatic clear_mem;
        for (int i = 0; i < MEMN; i++) mem[i] = '0;
    endtask

    // run the loaded program and compare with the reference
    task automatic execute(input string name);
        int cyc = 0;
        int saved_rd, saved_wr;
        bit trace_ok;
        run_ref();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(acc_out == '0, "R1", {name, " acc at reset"}, acc_out, 0);
        check(halted == 1'b0, "R1", {name, " stop flag at reset"}, halted, 0);
        rst_n = 1'b1;
        while (cyc < 5000) begin
            @(posedge clk);
            cyc++;
            #1;
            if (halted) break;
        end
        check(cyc == exp_cyc, "R8", {name, " cycles to stop"}, cyc, exp_cyc);
        check(acc_out == exp_acc, "R3 R5", {name, " final accumulator"}, acc_out, exp_acc);
        check(rlog_n > 0 && rlog[0] == '0, "R1", {name, " first read address"},
              rlog[0], 0);
        trace_ok = (rlog_n == exp_log_n);
        for (int i = 0; i < exp_log_n && i < LOGN; i++)
            if (rlog[i] != exp_log[i]) trace_ok = 1'b0;
        check(trace_ok, "R2", {name, " read address trace length"}, rlog_n, exp_log_n);
        check(wr_n == exp_wr_n, "R4", {name, " write count"}, wr_n, exp_wr_n);
        for (int i = 0; i < 16; i++)
            if (mem[DBASE + i] != ref_mem[DBASE + i]) begin
                check(1'b0, "R4", {name, " data word"}, mem[DBASE + i], ref_mem[DBASE + i]);
                break;
            end
        saved_rd = rlog_n; saved_wr = wr_n;
        repeat (10) @(posedge clk);
        #1;
        check(halted && rlog_n == saved_rd && wr_n == saved_wr, "R6",
              {name, " quiet after stop"}, rlog_n + wr_n, saved_rd + saved_wr);
    endtask

    function automatic logic [DW-1:0] ins(input logic [3:0] op, input int a);
        return {op, AW'(a)};
    endfunction

    initial begin
        void'($urandom(32'd2024));
        // directed: immediate stop with code 0
        clear_mem();
        mem[0] = ins(4'd0, 0);
        execute("stop0");

        // directed: wrap of the sum
        clear_mem();
        mem[DBASE] = 16'hFFFF; mem[DBASE + 1] = 16'h0002;
        mem[0] = ins(4'd1, DBASE);
        mem[1] = ins(4'd5, DBASE + 1);
        mem[2] = ins(4'd2, DBASE + 2);
        mem[3] = ins(4'hF, 0);
        execute("wrap");
        check(mem[DBASE + 2] == 16'h0001, "R5", "wrapped sum stored", mem[DBASE + 2], 1);

        // directed: store of reset accumulator, undefined stop code
        clear_mem();
        mem[DBASE + 3] = 16'hABCD;
        mem[0] = ins(4'd2, DBASE + 3);
        mem[1] = ins(4'd3, 0);
        execute("store_zero");
        check(mem[DBASE + 3] == 16'h0000, "R4", "store of zero accumulator", mem[DBASE + 3], 0);

        // random programs
        for (int t = 0; t < 40; t++) begin
            int n;
            logic [3:0] op;
            clear_mem();
            for (int i = 0; i < 16; i++) mem[DBASE + i] = DW'($urandom);
            n = 1 + $urandom % 30;
            for (int i = 0; i < n; i++) begin
                case ($urandom % 3)
                    0: op = 4'd1;
                    1: op = 4'd2;
                    default: op = 4'd5;
                endcase
                mem[i] = ins(op, DBASE + ($urandom % 16));
            end
            mem[n] = {stop_code(), AW'($urandom)};
            execute($sformatf("rand%0d", t));
        end
        report();
    end

endmodule